// File: doc/BRIEF.md
# Timeslot Transparent Receiver with Match-Start Capture

This block receives bytes from a serial time-division highway in transparent mode, with no framing. Serial bits are shifted in, most significant bit first, only on cycles where the timeslot strobe is high. Every eight strobed bits in a row make one byte. When the strobe drops partway through a byte, the partial byte is thrown away.

After it is enabled, the receiver hunts. It compares each completed byte with a programmable match character and discards it. The byte that equals the match character ends the hunt. That byte is not stored, but every byte after it goes into a 16-entry receive FIFO.

The match sets a sticky status flag and raises no interrupt. Software learns of it through the threshold interrupt, which fires when the FIFO level reaches a programmable count. When a byte arrives while the FIFO is full, that byte is dropped, an overrun interrupt is raised, and the end-of-frame flag is set as well. A loopback control feeds the neighbouring transmitter's serial output into the receiver in place of the line input.

Top module: `tsr_match_rx`

## Requirements
- R1: After reset the FIFO is empty (`fifo_empty`=1, `fifo_level`=0), both interrupts are low, all status bits read 0, and reception is disabled.
- R2: A byte is assembled MSB first from 8 consecutive cycles with `slot_en`=1. A cycle with `slot_en`=0 discards any partial byte.
- R3: While hunting, completed bytes are discarded. A byte equal to the match character (register address 1) ends the hunt and is not stored. Every later byte is stored in arrival order.
- R4: The match sets status bit 0 (register address 3) and leaves `irq_thr` and `irq_ovr` unchanged.
- R5: `irq_thr` is high exactly while the threshold (register address 2) is nonzero and `fifo_level` is at least the threshold. A threshold of 0 disables it. A threshold written during reception applies on the next compare.
- R6: A byte that completes while the FIFO holds 16 bytes and no pop is made is discarded. The stored bytes are kept. Status bit 1 (overrun) and status bit 2 (end-of-frame) are set, and `irq_ovr` goes high.
- R7: Reading register address 3 with `reg_re` returns the status and clears all status bits. `irq_ovr` follows status bit 1.
- R8: With control bit 1 (register address 0) set, the receiver takes its bits from `tx_ser_in` instead of `ser_in`.
- R9: Clearing control bit 0 stops reception. Bytes arriving while disabled are ignored, the FIFO contents are kept, and re-enabling starts a new hunt.
- R10: `fifo_data` shows the oldest stored byte. `fifo_pop` removes it, and a pop while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_in | input | 1 | Serial line data |
| tx_ser_in | input | 1 | Transmitter serial output, used in loopback |
| slot_en | input | 1 | Timeslot strobe; one data bit per high cycle |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears status on address 3) |
| reg_addr | input | 2 | 0 control, 1 match character, 2 threshold, 3 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| fifo_pop | input | 1 | Remove the oldest FIFO byte |
| fifo_data | output | 8 | Oldest FIFO byte |
| fifo_empty | output | 1 | FIFO holds no byte |
| fifo_level | output | 5 | Number of bytes stored |
| irq_thr | output | 1 | Threshold interrupt |
| irq_ovr | output | 1 | Overrun interrupt |

## Verification
The bound checker watches several rules on every cycle. The FIFO level never exceeds 16 and moves by at most one per cycle. It never grows while the receiver is disabled or still hunting. An overrun only begins when the FIFO is full, and the threshold interrupt never stands over an empty FIFO.

Some behaviour can only be shown by the bench's scenarios. These include the byte values that pass the match, the MSB-first order, and the discard of partial bytes. They also include the live change of the threshold, the clear-on-read of status, loopback source selection, and that the dropped byte never appears among the 16 kept ones.

// File: rtl/tsr_match_rx.sv
module tsr_match_rx #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int BW   = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_in,
  input  logic          tx_ser_in,
  input  logic          slot_en,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          fifo_pop,
  output logic [DW-1:0] fifo_data,
  output logic          fifo_empty,
  output logic [LW-1:0] fifo_level,
  output logic          irq_thr,
  output logic          irq_ovr
);

  logic          rx_en, lpbk, capture;
  logic [DW-1:0] match_chr, sh;
  logic [LW-1:0] thr, level;
  logic [BW-1:0] bcnt;
  logic [AW-1:0] wp, rp;
  logic          st_match, st_ovr, st_eof;
  logic [DW-1:0] mem [DEPTH];

  wire          rx_bit    = lpbk ? tx_ser_in : ser_in;
  wire [DW-1:0] nb        = {sh[DW-2:0], rx_bit};
  wire          byte_done = rx_en && slot_en && (bcnt == BW'(DW - 1));
  wire          hunting   = rx_en && !capture;
  wire          hit       = byte_done && hunting && (nb == match_chr);
  wire          full      = (level == LW'(DEPTH));
  wire          do_pop    = fifo_pop && (level != '0);
  wire          want      = byte_done && capture;
  wire          do_push   = want && (!full || do_pop);
  wire          ovr       = want && full && !do_pop;
  wire          st_rd     = reg_re && (reg_addr == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      sh   <= '0;
    end else if (!rx_en || !slot_en) begin
      bcnt <= '0;
    end else begin
      sh   <= nb;
      bcnt <= byte_done ? '0 : bcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      capture <= 1'b0;
    else if (!rx_en) capture <= 1'b0;
    else if (hit)    capture <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en     <= 1'b0;
      lpbk      <= 1'b0;
      match_chr <= '0;
      thr       <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        2'd0:    {lpbk, rx_en} <= reg_wdata[1:0];
        2'd1:    match_chr     <= reg_wdata;
        2'd2:    thr           <= reg_wdata[LW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_match <= 1'b0;
      st_ovr   <= 1'b0;
      st_eof   <= 1'b0;
    end else begin
      st_match <= hit | (st_match & !st_rd);
      st_ovr   <= ovr | (st_ovr & !st_rd);
      st_eof   <= ovr | (st_eof & !st_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= nb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      level <= level + LW'(do_push) - LW'(do_pop);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0:    reg_rdata[1:0]    = {lpbk, rx_en};
      2'd1:    reg_rdata         = match_chr;
      2'd2:    reg_rdata[LW-1:0] = thr;
      default: reg_rdata[2:0]    = {st_eof, st_ovr, st_match};
    endcase
  end

  assign fifo_data  = mem[rp];
  assign fifo_level = level;
  assign fifo_empty = (level == '0);
  assign irq_thr    = (thr != '0) && (level >= thr);
  assign irq_ovr    = st_ovr;

endmodule

module tsr_match_rx_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] fifo_level,
  input logic          fifo_empty,
  input logic          irq_thr,
  input logic          irq_ovr,
  input logic          rx_en,
  input logic          hunting
);

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));

  a_r10_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == $past(fifo_level)) || (fifo_level == $past(fifo_level) + 1'b1)
    || (fifo_level + 1'b1 == $past(fifo_level)));

  a_r9_no_store_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> fifo_level <= $past(fifo_level));

  a_r3_no_store_hunting: assert property (@(posedge clk) disable iff (!rst_n)
    hunting |=> fifo_level <= $past(fifo_level));

  a_r6_ovr_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_ovr) |-> $past(fifo_level) == LW'(DEPTH));

  a_r5_thr_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    irq_thr |-> !fifo_empty);

endmodule

bind tsr_match_rx tsr_match_rx_chk #(.DEPTH(DEPTH), .LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .fifo_empty(fifo_empty),
  .irq_thr(irq_thr), .irq_ovr(irq_ovr), .rx_en(rx_en), .hunting(hunting));

// File: tb/tsr_match_rx_tb.sv
module tsr_match_rx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_in = 1'b0, tx_ser_in = 1'b0, slot_en = 1'b0;
  logic reg_we = 1'b0, reg_re = 1'b0, fifo_pop = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata, fifo_data;
  logic [4:0] fifo_level;
  logic fifo_empty, irq_thr, irq_ovr;

  always #5 clk = ~clk;

  tsr_match_rx dut_i (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  bit m_en = 0, m_hunt = 1;
  int m_cnt = 0;
  logic [7:0] m_match = 8'h00;
  logic [7:0] st;

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_status(output logic [7:0] v);
    @(negedge clk); reg_re = 1'b1; reg_addr = 2'd3;
    #1 v = reg_rdata;
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic send_bits(logic [7:0] b, int n, bit lb);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk);
      slot_en = 1'b1;
      ser_in = lb ? ~b[i] : b[i];
      tx_ser_in = lb ? b[i] : ~b[i];
    end
    @(negedge clk); slot_en = 1'b0;
  endtask

  // driver: sends a byte and pushes what the scoreboard expects
  task automatic send_byte(logic [7:0] b, bit lb = 0);
    send_bits(b, 8, lb);
    if (m_en) begin
      if (m_hunt) begin
        if (b == m_match) m_hunt = 0;
      end else if (m_cnt < 16) begin
        exp_q.push_back(b);
        m_cnt++;
      end
    end
  endtask

  // monitor: pops results and compares them with the queue
  task automatic drain(string req);
    while (exp_q.size() > 0) begin
      @(negedge clk);
      check(req, fifo_data, exp_q.pop_front());
      fifo_pop = 1'b1;
      @(negedge clk); fifo_pop = 1'b0;
      m_cnt--;
    end
    @(negedge clk);
    check(req, fifo_empty, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 empty", fifo_empty, 1);
    check("R1 level", fifo_level, 0);
    check("R1 irqs", {irq_thr, irq_ovr}, 0);
    rd_status(st); check("R1 status", st, 0);

    wr(2'd1, 8'hA5); m_match = 8'hA5;
    wr(2'd0, 8'h01); m_en = 1;
    // R3 hunt discards
    send_byte(8'h11); send_byte(8'h22);
    check("R3 hunt discards", fifo_level, 0);
    rd_status(st); check("R4 no match yet", st[0], 0);
    send_byte(8'hA5);
    check("R3 match byte not stored", fifo_level, 0);
    check("R4 no irq on match", {irq_thr, irq_ovr}, 0);
    rd_status(st); check("R4 match bit", st[0], 1);
    rd_status(st); check("R7 cleared on read", st, 0);

    // R5 threshold
    wr(2'd2, 8'd1);
    send_byte(8'h3C);
    check("R5 thr=1 fires", irq_thr, 1);
    send_byte(8'hA5);
    check("R3 later match char stored", fifo_level, 2);
    wr(2'd2, 8'd3);
    check("R5 live thr change", irq_thr, 0);
    send_byte(8'h5A);
    check("R5 thr=3 reached", irq_thr, 1);
    wr(2'd2, 8'd0);
    check("R5 thr=0 disables", irq_thr, 0);
    drain("R10 order");
    @(negedge clk); fifo_pop = 1'b1;
    @(negedge clk); fifo_pop = 1'b0;
    check("R10 pop on empty", fifo_level, 0);

    // R2 partial byte discarded
    send_bits(8'hF0, 4, 0);
    send_byte(8'h81);
    check("R2 one byte", fifo_level, 1);
    drain("R2 value");

    // R6 overrun
    for (int i = 0; i < 16; i++) send_byte(8'(i * 7 + 3));
    check("R6 full", fifo_level, 16);
    check("R6 no ovr yet", irq_ovr, 0);
    send_byte(8'hEE);
    check("R6 level kept", fifo_level, 16);
    check("R6 irq_ovr", irq_ovr, 1);
    rd_status(st); check("R6 ovr+eof bits", st[2:1], 2'b11);
    check("R7 irq_ovr cleared", irq_ovr, 0);
    drain("R6 kept bytes");

    // R9 disable
    wr(2'd0, 8'h00); m_en = 0; m_hunt = 1;
    send_byte(8'h77);
    check("R9 ignored while off", fifo_level, 0);
    wr(2'd0, 8'h01); m_en = 1;
    send_byte(8'h99);
    check("R9 hunts again", fifo_level, 0);
    send_byte(8'hA5); send_byte(8'h42);
    check("R9 capture after rehunt", fifo_level, 1);
    drain("R9 value");

    // R8 loopback
    wr(2'd0, 8'h03);
    send_byte(8'h6D, 1);
    check("R8 loopback count", fifo_level, 1);
    drain("R8 loopback data");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule